// File: doc/BRIEF.md
# Indirect ROM Lookup Sequencer

This block is the program-sequencing slice of a small 4-bit controller core. It keeps an 11-bit program counter and a three-entry hardware return stack. It carries out two indirect operations that read the program ROM as data. The first is a table lookup. It fetches an 8-bit ROM word into a Q holding latch and then resumes with the next instruction. The second is an indirect jump. It rewrites the low byte of the program counter with a ROM word. Both operations build their ROM address from the three high PC bits, the 4-bit accumulator operand and the 4-bit RAM-data operand.

The surrounding core decodes instructions and presents a one-cycle strobe with a 3-bit operation code. On the same cycle it presents the two nibble operands and a skip flag. The block drives the ROM address. It takes the ROM word back combinationally in the same cycle. While busy is high, the core holds off.

Plain step, direct call and return are also sequenced here, so the stack can be filled and read back. The lookup does not fetch through a separate pointer. It pushes the return address, aims the PC at the table entry, and then pops the return address back. Because of this, the value held in the deepest stack entry before a lookup is lost.

Top module: `tblseq_top`

## Requirements
- R1: After reset, pc_o, q_o and every stack entry are zero, busy_o is low, and rom_addr_o equals pc_o.
- R2: A strobe with op 0 (step), or with op 5, 6 or 7, advances the PC by one. A strobe with skip_i high advances the PC by one for any op, takes one cycle, and leaves Q and the stack unchanged.
- R3: An accepted lookup (op 1) raises busy_o for exactly the following cycle. During that cycle, both pc_o and rom_addr_o equal {PC[10:8], acc_i, mem_i}, as sampled at the strobe.
- R4: At the end of a lookup, q_o holds the ROM word read during the busy cycle, and the PC equals the lookup's own address plus one.
- R5: A lookup pushes the return address and then pops it. The pop leaves the former second entry duplicated in the deepest entry, so the value the deepest entry held before the lookup can no longer be returned to.
- R6: An accepted indirect jump (op 2) raises busy_o for one cycle with rom_addr_o = {PC[10:8], acc_i, mem_i}. It then sets PC[7:0] to that ROM word, keeps PC[10:8], and leaves Q and the stack unchanged.
- R7: A strobe that arrives while busy_o is high is ignored.
- R8: A call (op 3) pushes PC+1 onto the stack, discarding the deepest entry. It loads the PC with {PC[10:8], acc_i, mem_i} in one cycle.
- R9: A return (op 4) loads the PC from the top entry and shifts the other entries up one place. The deepest entry keeps its value.
- R10: PC arithmetic is modulo 2^11, so advancing from 0x7FF gives 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_vld_i | input | 1 | Instruction strobe, one cycle per instruction |
| instr_op_i | input | 3 | Operation: 0 step, 1 lookup, 2 indirect jump, 3 call, 4 return, 5-7 step |
| skip_i | input | 1 | The strobed instruction is skipped |
| acc_i | input | 4 | Accumulator operand, address bits 7:4 |
| mem_i | input | 4 | RAM-data operand, address bits 3:0 |
| rom_addr_o | output | 11 | ROM address |
| rom_data_i | input | 8 | ROM word at rom_addr_o, same cycle |
| q_o | output | 8 | Q latch |
| busy_o | output | 1 | Second cycle of a lookup or jump |
| pc_o | output | 11 | Program counter |

## Verification
The stack cannot be read directly, so a corrupt stack entry only shows up when a return or a lookup's resume puts it on pc_o. The bench therefore fills all three entries with distinct addresses, runs a lookup, and unwinds with returns. Any wrong shift or lost entry then shows on pc_o within one cycle of the return that exposes it. A wrong address formation shows on rom_addr_o during the busy cycle itself, and it shows one cycle later as a wrong q_o or PC low byte.

// File: rtl/tblseq_pkg.sv
package tblseq_pkg;

    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_LOOKUP = 3'd1,
        OP_JUMP   = 3'd2,
        OP_CALL   = 3'd3,
        OP_RET    = 3'd4
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_JUMP   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tblseq_stack.sv
module tblseq_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o
);
    localparam int LAST = DEPTH - 1;

    logic [W-1:0] lvl_d [DEPTH];
    logic [W-1:0] lvl_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
            always_comb begin
                lvl_d[i] = lvl_q[i];
                if (push_i) begin
                    if (i == 0) lvl_d[i] = din_i;
                    else        lvl_d[i] = lvl_q[(i == 0) ? 0 : i - 1];
                end else if (pop_i) begin
                    if (i != LAST) lvl_d[i] = lvl_q[(i == LAST) ? LAST : i + 1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lvl_q[i] <= '0;
                else        lvl_q[i] <= lvl_d[i];
            end
        end
    endgenerate

    assign top_o = lvl_q[0];

endmodule

// File: rtl/tblseq_ctrl.sv
module tblseq_ctrl
    import tblseq_pkg::*;
#(
    parameter int PC_W  = 11,
    parameter int NIB_W = 4,
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [2:0]       op_i,
    input  logic             skip_i,
    input  logic [NIB_W-1:0] acc_i,
    input  logic [NIB_W-1:0] mem_i,
    input  logic [DAT_W-1:0] rom_data_i,
    input  logic [PC_W-1:0]  stk_top_i,
    output logic             push_o,
    output logic             pop_o,
    output logic [PC_W-1:0]  push_val_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [DAT_W-1:0] q_o,
    output logic             busy_o,
    output logic [PC_W-1:0]  rom_addr_o
);
    localparam int LOW_W = 2 * NIB_W;
    localparam int HI_W  = PC_W - LOW_W;

    typedef struct packed {
        seq_state_e       st;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  fa;
        logic [DAT_W-1:0] q;
    } ctrl_s;

    ctrl_s r_q, r_d;

    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] ind_addr;
    logic            accept;

    assign pc_inc   = r_q.pc + PC_W'(1);
    assign ind_addr = {r_q.pc[PC_W-1:LOW_W], acc_i, mem_i};
    assign accept   = strobe_i && (r_q.st == ST_IDLE);

    always_comb begin
        r_d        = r_q;
        push_o     = 1'b0;
        pop_o      = 1'b0;
        push_val_o = pc_inc;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (skip_i) begin
                        r_d.pc = pc_inc;
                    end else begin
                        case (op_i)
                            OP_LOOKUP: begin
                                push_o = 1'b1;
                                r_d.fa = ind_addr;
                                r_d.pc = ind_addr;
                                r_d.st = ST_LOOKUP;
                            end
                            OP_JUMP: begin
                                r_d.fa = ind_addr;
                                r_d.st = ST_JUMP;
                            end
                            OP_CALL: begin
                                push_o = 1'b1;
                                r_d.pc = ind_addr;
                            end
                            OP_RET: begin
                                pop_o  = 1'b1;
                                r_d.pc = stk_top_i;
                            end
                            default: r_d.pc = pc_inc;
                        endcase
                    end
                end
            end
            ST_LOOKUP: begin
                r_d.q  = rom_data_i;
                pop_o  = 1'b1;
                r_d.pc = stk_top_i;
                r_d.st = ST_IDLE;
            end
            ST_JUMP: begin
                r_d.pc = {r_q.pc[PC_W-1:PC_W-HI_W], rom_data_i[LOW_W-1:0]};
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_IDLE;
            r_q.pc <= '0;
            r_q.fa <= '0;
            r_q.q  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o       = r_q.pc;
    assign q_o        = r_q.q;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign rom_addr_o = busy_o ? r_q.fa : r_q.pc;

endmodule

// File: rtl/tblseq_top.sv
module tblseq_top #(
    parameter int PC_W      = 11,
    parameter int NIB_W     = 4,
    parameter int DAT_W     = 8,
    parameter int STK_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_vld_i,
    input  logic [2:0]       instr_op_i,
    input  logic             skip_i,
    input  logic [NIB_W-1:0] acc_i,
    input  logic [NIB_W-1:0] mem_i,
    output logic [PC_W-1:0]  rom_addr_o,
    input  logic [DAT_W-1:0] rom_data_i,
    output logic [DAT_W-1:0] q_o,
    output logic             busy_o,
    output logic [PC_W-1:0]  pc_o
);
    logic            push;
    logic            pop;
    logic [PC_W-1:0] push_val;
    logic [PC_W-1:0] stk_top;

    tblseq_ctrl #(
        .PC_W (PC_W),
        .NIB_W(NIB_W),
        .DAT_W(DAT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (instr_vld_i),
        .op_i      (instr_op_i),
        .skip_i    (skip_i),
        .acc_i     (acc_i),
        .mem_i     (mem_i),
        .rom_data_i(rom_data_i),
        .stk_top_i (stk_top),
        .push_o    (push),
        .pop_o     (pop),
        .push_val_o(push_val),
        .pc_o      (pc_o),
        .q_o       (q_o),
        .busy_o    (busy_o),
        .rom_addr_o(rom_addr_o)
    );

    tblseq_stack #(
        .W    (PC_W),
        .DEPTH(STK_DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push_i(push),
        .pop_i (pop),
        .din_i (push_val),
        .top_o (stk_top)
    );

endmodule

// File: rtl/tblseq_chk.sv
module tblseq_chk #(
    parameter int PC_W  = 11,
    parameter int NIB_W = 4,
    parameter int DAT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_vld_i,
    input logic [2:0]       instr_op_i,
    input logic             skip_i,
    input logic [NIB_W-1:0] acc_i,
    input logic [NIB_W-1:0] mem_i,
    input logic [PC_W-1:0]  rom_addr_o,
    input logic [DAT_W-1:0] rom_data_i,
    input logic [DAT_W-1:0] q_o,
    input logic             busy_o,
    input logic [PC_W-1:0]  pc_o
);
    localparam int LOW_W = 2 * NIB_W;

    logic go;
    assign go = instr_vld_i && !busy_o && !skip_i;

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o); // R7

    AST_LOOKUP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (go && instr_op_i == 3'd1) |=>
        (busy_o && rom_addr_o == $past({pc_o[PC_W-1:LOW_W], acc_i, mem_i})
                && pc_o == rom_addr_o)); // R3

    AST_LOOKUP_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (go && instr_op_i == 3'd1) |=> ##1 (pc_o == $past(pc_o, 2) + PC_W'(1))); // R4

    AST_JUMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (go && instr_op_i == 3'd2) |=> ##1
        (pc_o[PC_W-1:LOW_W] == $past(pc_o[PC_W-1:LOW_W], 2)
         && pc_o[LOW_W-1:0] == $past(rom_data_i[LOW_W-1:0]))); // R6

    AST_SKIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && !busy_o && skip_i) |=>
        (pc_o == $past(pc_o) + PC_W'(1) && !busy_o && $stable(q_o))); // R2

    AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(q_o)); // R4

endmodule

bind tblseq_top tblseq_chk #(
    .PC_W (PC_W),
    .NIB_W(NIB_W),
    .DAT_W(DAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_vld_i(instr_vld_i),
    .instr_op_i (instr_op_i),
    .skip_i     (skip_i),
    .acc_i      (acc_i),
    .mem_i      (mem_i),
    .rom_addr_o (rom_addr_o),
    .rom_data_i (rom_data_i),
    .q_o        (q_o),
    .busy_o     (busy_o),
    .pc_o       (pc_o)
);

// File: tb/tblseq_top_tb.sv
`timescale 1ns/1ps
module tblseq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        skip = 1'b0;
    logic [3:0]  acc = 4'd0;
    logic [3:0]  mem = 4'd0;
    logic [10:0] rom_addr;
    logic [7:0]  rom_data;
    logic [7:0]  q;
    logic        busy;
    logic [10:0] pc;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int m_pc = 0;
    int m_q = 0;
    int m_fa = 0;
    int m_state = 0; // 0 idle, 1 lookup fetch, 2 jump fetch
    int m_stk[$] = '{0, 0, 0};

    always #2 clk = ~clk;

    function automatic int rom_fn(int a);
        return (a * 37 + 11 + (a >> 5)) & 8'hFF;
    endfunction

    assign rom_data = 8'(rom_fn(int'(rom_addr)));

    tblseq_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_vld_i(vld),
        .instr_op_i (op),
        .skip_i     (skip),
        .acc_i      (acc),
        .mem_i      (mem),
        .rom_addr_o (rom_addr),
        .rom_data_i (rom_data),
        .q_o        (q),
        .busy_o     (busy),
        .pc_o       (pc)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "pc", int'(pc), m_pc);
        check(tag, "q", int'(q), m_q);
        check(tag, "busy", int'(busy), (m_state != 0) ? 1 : 0);
        check(tag, "rom_addr", int'(rom_addr), (m_state != 0) ? m_fa : m_pc);
    endtask

    task automatic model_edge(bit v, int o, int a, int m, bit sk);
        int ind;
        ind = (m_pc & 'h700) | (a << 4) | m;
        if (m_state == 1) begin
            m_q = rom_fn(m_fa);
            m_pc = m_stk.pop_front();
            m_stk.push_back(m_stk[1]);
            m_state = 0;
        end else if (m_state == 2) begin
            m_pc = (m_pc & 'h700) | rom_fn(m_fa);
            m_state = 0;
        end else if (v) begin
            if (sk) m_pc = (m_pc + 1) & 'h7FF;
            else if (o == 1) begin
                m_stk.push_front((m_pc + 1) & 'h7FF);
                void'(m_stk.pop_back());
                m_fa = ind; m_pc = ind; m_state = 1;
            end else if (o == 2) begin
                m_fa = ind; m_state = 2;
            end else if (o == 3) begin
                m_stk.push_front((m_pc + 1) & 'h7FF);
                void'(m_stk.pop_back());
                m_pc = ind;
            end else if (o == 4) begin
                m_pc = m_stk.pop_front();
                m_stk.push_back(m_stk[1]);
            end else m_pc = (m_pc + 1) & 'h7FF;
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(bit v, int o, int a, int m, bit sk, string tag);
        vld = v; op = 3'(o); acc = 4'(a); mem = 4'(m); skip = sk;
        @(posedge clk);
        model_edge(v, o, a, m, sk);
        @(negedge clk);
        vld = 1'b0; skip = 1'b0;
        compare(tag);
    endtask

    initial begin
        int sb_before;
        int sc_before;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // step and unused codes
        cyc(1, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, "R2");
        for (int k = 5; k < 8; k++) cyc(1, k, 3, 3, 0, "R2");
        // skipped versions of every op
        for (int k = 0; k < 8; k++) cyc(1, k, 9, 6, 1, "R2");
        cyc(0, 0, 0, 0, 0, "R2");

        // fill the stack with three distinct return addresses
        cyc(1, 3, 1, 2, 0, "R8");
        cyc(1, 3, 3, 4, 0, "R8");
        cyc(1, 3, 5, 6, 0, "R8");
        sb_before = m_stk[1];
        sc_before = m_stk[2];

        // lookup, with a strobe during busy that must be ignored
        cyc(1, 1, 4'hA, 4'h7, 0, "R3");
        check("R3", "pc during fetch", int'(pc), 'h0A7);
        cyc(1, 3, 4'hF, 4'hF, 0, "R7");
        check("R4", "q after lookup", int'(q), rom_fn('h0A7));
        check("R4", "pc resumes", int'(pc), 'h057);

        // unwind: the deepest value from before the lookup must be gone
        cyc(1, 4, 0, 0, 0, "R9");
        cyc(1, 4, 0, 0, 0, "R9");
        cyc(1, 4, 0, 0, 0, "R5");
        check("R5", "third return gives old second entry", int'(pc), sb_before);
        checks++;
        if (int'(pc) == sc_before) begin
            fails++;
            $display("FAIL R5 old deepest entry returned: actual 0x%0h expected not 0x%0h",
                     pc, sc_before);
        end

        // indirect jump with an ignored strobe in the busy cycle
        cyc(1, 2, 4'h3, 4'hC, 0, "R6");
        cyc(1, 2, 4'h1, 4'h1, 0, "R7");
        check("R6", "jump low byte", int'(pc[7:0]), rom_fn(int'({pc[10:8], 8'h3C})));
        // overflow the stack with four calls, then four returns
        for (int k = 0; k < 4; k++) cyc(1, 3, k + 2, k, 0, "R8");
        for (int k = 0; k < 4; k++) cyc(1, 4, 0, 0, 0, "R9");

        // walk the PC up to the top of its range
        cyc(1, 2, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, "R6");
        while (m_pc != 'h7FF) cyc(1, 0, 0, 0, 0, "R10");
        cyc(1, 1, 4'h2, 4'h5, 0, "R3");
        cyc(0, 0, 0, 0, 0, "R4");
        check("R10", "lookup resume wraps", int'(pc), 'h000);
        while (m_pc != 'h7FF) cyc(1, 0, 0, 0, 0, "R10");
        cyc(1, 0, 0, 0, 0, "R10");
        check("R10", "step wraps", int'(pc), 'h000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule